// File: doc/BRIEF.md
# Open-Row DRAM Access Controller

This block sits between a simple requester and a small DRAM array of 16 supercells of 8 bits each, arranged as 4 rows by 4 columns. The array and its internal row buffer are modelled in logic inside the block. A requester hands over one read or write at a time, naming a row, a column and (for writes) a byte, through a valid/ready handshake. The block then drives a narrow shared address bus. It strobes the row number with a row strobe and the column number with a column strobe, and it uses a close strobe when the open row is written back.

After an access the row stays open in the row buffer. A following access to that same row costs only one column strobe. An access to another row first closes the open one and then opens the new row. Independently of traffic, a refresh timer marks a refresh as due at a fixed period. The refresh then goes ahead of any waiting request: the block closes the open row if there is one, opens the next row in ascending order and closes it again. Over time every row is rewritten within a bounded window.

Top module: `pgdram_ctrl`

## Requirements
- R1: Directly after reset the block is ready for a request, no strobe is active, no response is flagged and no refresh is in progress.
- R2: In any cycle at most one of the row strobe, column strobe and close strobe is active. During a row strobe the bus carries the row number, and during a column strobe it carries the column number.
- R3: A column strobe occurs only while a row is open. For a read, the response flag is high in that same cycle and the data is the addressed supercell of the open row.
- R4: A request to the row that is already open is served by a column strobe alone, in the cycle after acceptance. Four reads of one row starting from a closed row cost exactly one row strobe.
- R5: A request to a row other than the open one gives a close strobe, a row strobe and a column strobe in the three cycles after acceptance. A row strobe is never issued while a row is open.
- R6: A write updates the supercell in the row buffer, so a later read of the same open row returns the new byte. The close strobe writes the buffer back to the array, so the byte is still there after another row has been used.
- R7: A refresh becomes due once every REFRESH_PERIOD cycles. It consists of a row strobe with the refresh flag high, followed by a close strobe. Refreshed rows advance 0,1,2,3 and wrap. With no traffic and no row open, consecutive refreshes are exactly REFRESH_PERIOD cycles apart, and under traffic never more than REFRESH_PERIOD+8 cycles apart.
- R8: A due refresh takes priority over requests. The block does not accept a request while a refresh is due or running, and a due refresh found by an idle sequencer starts in the next cycle. Refresh never alters stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | 2 | Row of the supercell |
| req_col | input | 2 | Column of the supercell |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_rdata | output | 8 | Read data |
| bus_addr | output | 2 | Shared row/column address bus |
| row_stb | output | 1 | Row strobe: load the addressed row into the buffer |
| col_stb | output | 1 | Column strobe: access the addressed supercell in the buffer |
| pre_stb | output | 1 | Close strobe: write the buffer back and close the row |
| rfsh_busy | output | 1 | A refresh sequence is in progress |

## Verification
Several rules are checked on every cycle: the strobes are mutually exclusive, a column strobe needs an open row, a row strobe needs a closed row, hits and misses follow their fixed strobe sequences after acceptance, a due refresh found by an idle sequencer starts at once, and the gap between refreshes stays bounded. The bench scenarios show what depends on stored contents and counting. These are read data against a reference copy of all sixteen supercells, the write-back across row switches and refreshes, the count of one row strobe for four same-row reads, the ascending refresh order and the exact idle refresh spacing.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_OPEN,
    ST_COL,
    ST_RCLOSE0,
    ST_ROPEN,
    ST_RCLOSE
  } pg_state_e;

  // advance an index by one, wrapping to zero at n
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // true when a refresh state
  function automatic logic is_rfsh_state(input pg_state_e s);
    return (s == ST_RCLOSE0) || (s == ST_ROPEN) || (s == ST_RCLOSE);
  endfunction

endpackage

// File: rtl/pgdram_array.sv
module pgdram_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic [RW-1:0] act_row,
  input  logic          wb,
  input  logic [RW-1:0] wb_row,
  input  logic          col_wr,
  input  logic [CW-1:0] col_idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q    [ROWS][COLS];
  logic [DW-1:0] rowbuf_q [COLS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem_q[r][c] <= '0;
      for (int c = 0; c < COLS; c++)
        rowbuf_q[c] <= '0;
    end else begin
      if (act)
        for (int c = 0; c < COLS; c++)
          rowbuf_q[c] <= mem_q[act_row][c];
      if (col_wr)
        rowbuf_q[col_idx] <= wdata;
      if (wb)
        for (int c = 0; c < COLS; c++)
          mem_q[wb_row][c] <= rowbuf_q[c];
    end
  end

  assign rdata = rowbuf_q[col_idx];

endmodule

// File: rtl/pgdram_refresh.sv
module pgdram_refresh #(
  parameter int ROWS           = 4,
  parameter int REFRESH_PERIOD = 64,
  localparam int RW            = $clog2(ROWS),
  localparam int CNTW          = $clog2(REFRESH_PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  output logic          due,
  output logic [RW-1:0] row
);
  import pgdram_pkg::*;

  logic [CNTW-1:0] cnt_q;
  logic            due_q;
  logic [RW-1:0]   row_q;
  logic            tick;

  assign tick = (cnt_q == CNTW'(REFRESH_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
      row_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (ack) begin
        due_q <= 1'b0;
        row_q <= RW'(wrap_inc(int'(row_q), ROWS));
      end
      if (tick)
        due_q <= 1'b1;
    end
  end

  assign due = due_q;
  assign row = row_q;

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int AW  = (RW > CW) ? RW : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic [DW-1:0] req_wdata,
  input  logic          rfsh_due,
  input  logic [RW-1:0] rfsh_row,
  output logic          req_ready,
  output logic          row_stb,
  output logic          col_stb,
  output logic          pre_stb,
  output logic [AW-1:0] bus_addr,
  output logic          rfsh_busy,
  output logic          rfsh_ack,
  output logic          row_open,
  output logic [RW-1:0] open_row,
  output logic [RW-1:0] act_row,
  output logic          fsm_idle,
  output logic          cur_we,
  output logic [CW-1:0] cur_col,
  output logic [DW-1:0] cur_wdata
);
  import pgdram_pkg::*;

  pg_state_e     state_q, state_d;
  logic          open_q;
  logic [RW-1:0] open_row_q;
  logic          we_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [DW-1:0] wdata_q;
  logic          accept;

  function automatic logic row_hit(input logic is_open, input logic [RW-1:0] a,
                                   input logic [RW-1:0] b);
    return is_open && (a == b);
  endfunction

  assign fsm_idle  = (state_q == ST_IDLE);
  assign req_ready = fsm_idle && !rfsh_due;
  assign accept    = req_valid && req_ready;
  assign rfsh_busy = is_rfsh_state(state_q);

  always_comb begin
    state_d  = state_q;
    row_stb  = 1'b0;
    col_stb  = 1'b0;
    pre_stb  = 1'b0;
    rfsh_ack = 1'b0;
    bus_addr = '0;
    act_row  = row_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rfsh_due)
          state_d = open_q ? ST_RCLOSE0 : ST_ROPEN;
        else if (accept) begin
          if (row_hit(open_q, open_row_q, req_row)) state_d = ST_COL;
          else if (open_q)                          state_d = ST_CLOSE;
          else                                      state_d = ST_OPEN;
        end
      end
      ST_CLOSE: begin
        pre_stb = 1'b1;
        state_d = ST_OPEN;
      end
      ST_OPEN: begin
        row_stb  = 1'b1;
        bus_addr = AW'(row_q);
        state_d  = ST_COL;
      end
      ST_COL: begin
        col_stb  = 1'b1;
        bus_addr = AW'(col_q);
        state_d  = ST_IDLE;
      end
      ST_RCLOSE0: begin
        pre_stb = 1'b1;
        state_d = ST_ROPEN;
      end
      ST_ROPEN: begin
        row_stb  = 1'b1;
        rfsh_ack = 1'b1;
        act_row  = rfsh_row;
        bus_addr = AW'(rfsh_row);
        state_d  = ST_RCLOSE;
      end
      ST_RCLOSE: begin
        pre_stb = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      open_q     <= 1'b0;
      open_row_q <= '0;
      we_q       <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wdata_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q    <= req_we;
        row_q   <= req_row;
        col_q   <= req_col;
        wdata_q <= req_wdata;
      end
      if (pre_stb)
        open_q <= 1'b0;
      if (row_stb) begin
        open_q     <= 1'b1;
        open_row_q <= act_row;
      end
    end
  end

  assign row_open  = open_q;
  assign open_row  = open_row_q;
  assign cur_we    = we_q;
  assign cur_col   = col_q;
  assign cur_wdata = wdata_q;

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
  parameter int ROWS           = 4,
  parameter int COLS           = 4,
  parameter int DW             = 8,
  parameter int REFRESH_PERIOD = 64,
  localparam int RW            = $clog2(ROWS),
  localparam int CW            = $clog2(COLS),
  localparam int AW            = (RW > CW) ? RW : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          row_stb,
  output logic          col_stb,
  output logic          pre_stb,
  output logic          rfsh_busy
);

  logic          rfsh_due;
  logic [RW-1:0] rfsh_row;
  logic          rfsh_ack;
  logic          row_open;
  logic [RW-1:0] open_row;
  logic [RW-1:0] act_row;
  logic          fsm_idle;
  logic          cur_we;
  logic [CW-1:0] cur_col;
  logic [DW-1:0] cur_wdata;
  logic [DW-1:0] rd_data;

  pgdram_refresh #(.ROWS(ROWS), .REFRESH_PERIOD(REFRESH_PERIOD)) u_rfsh (
    .clk(clk), .rst_n(rst_n), .ack(rfsh_ack), .due(rfsh_due), .row(rfsh_row)
  );

  pgdram_seq #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_row(req_row),
    .req_col(req_col), .req_wdata(req_wdata),
    .rfsh_due(rfsh_due), .rfsh_row(rfsh_row),
    .req_ready(req_ready), .row_stb(row_stb), .col_stb(col_stb),
    .pre_stb(pre_stb), .bus_addr(bus_addr), .rfsh_busy(rfsh_busy),
    .rfsh_ack(rfsh_ack), .row_open(row_open), .open_row(open_row),
    .act_row(act_row), .fsm_idle(fsm_idle), .cur_we(cur_we),
    .cur_col(cur_col), .cur_wdata(cur_wdata)
  );

  pgdram_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .act(row_stb), .act_row(act_row),
    .wb(pre_stb), .wb_row(open_row),
    .col_wr(col_stb && cur_we), .col_idx(cur_col),
    .wdata(cur_wdata), .rdata(rd_data)
  );

  assign rsp_valid = col_stb && !cur_we;
  assign rsp_rdata = rd_data;

endmodule

// File: rtl/pgdram_chk.sv
module pgdram_chk #(
  parameter int RW             = 2,
  parameter int REFRESH_PERIOD = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [RW-1:0] req_row,
  input logic          row_stb,
  input logic          col_stb,
  input logic          pre_stb,
  input logic          rfsh_busy,
  input logic          row_open,
  input logic [RW-1:0] open_row,
  input logic          rfsh_due,
  input logic          fsm_idle
);

  logic [31:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  since_q <= '0;
    else if (row_stb && rfsh_busy) since_q <= '0;
    else if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 1;
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_stb, col_stb, pre_stb}));

  a_r3_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |-> row_open);

  a_r5_open_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |-> !row_open);

  a_r4_hit_col_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && row_open && req_row == open_row) |=> (col_stb && !row_stb));

  a_r5_miss_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && row_open && req_row != open_row)
      |=> pre_stb ##1 (row_stb && !rfsh_busy) ##1 col_stb);

  a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_due && fsm_idle) |=> rfsh_busy);

  a_r7_refresh_bound: assert property (@(posedge clk) disable iff (!rst_n)
    since_q <= 32'(REFRESH_PERIOD + 8));

endmodule

bind pgdram_ctrl pgdram_chk #(.RW(RW), .REFRESH_PERIOD(REFRESH_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_row(req_row), .row_stb(row_stb), .col_stb(col_stb), .pre_stb(pre_stb),
  .rfsh_busy(rfsh_busy), .row_open(row_open), .open_row(open_row),
  .rfsh_due(rfsh_due), .fsm_idle(fsm_idle)
);

// File: tb/test_pgdram_ctrl.sv
`timescale 1ns/1ps
module test_pgdram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [1:0] req_row = '0, req_col = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid, row_stb, col_stb, pre_stb, rfsh_busy;
  logic [7:0] rsp_rdata;
  logic [1:0] bus_addr;

  pgdram_ctrl #(.ROWS(4), .COLS(4), .DW(8), .REFRESH_PERIOD(PER)) i_pgdram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .row_stb(row_stb), .col_stb(col_stb), .pre_stb(pre_stb), .rfsh_busy(rfsh_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [7:0] ref_mem [4][4];
  logic [7:0] exp_q [$];
  int drv_row = 0, drv_col = 0;
  int n_ras = 0, n_cas = 0, n_pre = 0;
  int pre_cyc = -1, ras_cyc = -1, cas_cyc = -1;
  int exp_rfsh = 0, last_rfsh = -1;
  bit spacing_chk = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (row_stb && !rfsh_busy) begin
        n_ras++; ras_cyc = cyc;
        chk("R2 row address on bus", bus_addr == 2'(drv_row), int'(bus_addr), drv_row);
      end
      if (col_stb) begin
        n_cas++; cas_cyc = cyc;
        chk("R2 column address on bus", bus_addr == 2'(drv_col), int'(bus_addr), drv_col);
      end
      if (pre_stb && !rfsh_busy) begin
        n_pre++; pre_cyc = cyc;
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0)
          chk("R3 unexpected read response", 1'b0, int'(rsp_rdata), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk("R3/R6 read data", rsp_rdata == e, int'(rsp_rdata), int'(e));
        end
      end
      if (row_stb && rfsh_busy) begin
        chk("R7 refresh row order", bus_addr == 2'(exp_rfsh), int'(bus_addr), exp_rfsh);
        chk("R8 no acceptance during refresh", req_ready == 1'b0, int'(req_ready), 0);
        if (spacing_chk && last_rfsh >= 0)
          chk("R7 idle refresh spacing", (cyc - last_rfsh) == PER, cyc - last_rfsh, PER);
        exp_rfsh = (exp_rfsh + 1) % 4;
        last_rfsh = cyc;
      end
    end
  end

  // driver: called at a negative edge
  task automatic do_op(input logic we, input int r, input int c, input logic [7:0] d);
    drv_row = r; drv_col = c;
    if (we) ref_mem[r][c] = d;
    else    exp_q.push_back(ref_mem[r][c]);
    req_we = we; req_row = 2'(r); req_col = 2'(c); req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic wait_after_refresh();
    while (!rfsh_busy) @(negedge clk);
    while (rfsh_busy) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0, p0, c0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        ref_mem[r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", req_ready == 1'b1, int'(req_ready), 1);
    chk("R1 no strobes after reset", {row_stb, col_stb, pre_stb} == 3'b000,
        int'({row_stb, col_stb, pre_stb}), 0);
    chk("R1 no response/refresh after reset", {rsp_valid, rfsh_busy} == 2'b00,
        int'({rsp_valid, rfsh_busy}), 0);

    // fill row 2, then four same-row reads from a closed row (R4)
    wait_after_refresh();
    for (int c = 0; c < 4; c++) do_op(1'b1, 2, c, 8'(8'h20 + c));
    wait_after_refresh();
    r0 = n_ras; c0 = n_cas;
    for (int c = 0; c < 4; c++) do_op(1'b0, 2, c, 8'h00);
    chk("R4 one row strobe for four same-row reads", (n_ras - r0) == 1, n_ras - r0, 1);
    chk("R4 four column strobes", (n_cas - c0) == 4, n_cas - c0, 4);

    // R6 write then hit read; R5 miss sequence; R6 write-back
    wait_after_refresh();
    do_op(1'b1, 0, 1, 8'hA5);
    do_op(1'b0, 0, 1, 8'h00);
    p0 = n_pre; r0 = n_ras;
    do_op(1'b0, 3, 2, 8'h00);
    chk("R5 one close strobe on miss", (n_pre - p0) == 1, n_pre - p0, 1);
    chk("R5 one row strobe on miss", (n_ras - r0) == 1, n_ras - r0, 1);
    chk("R5 row strobe follows close", ras_cyc == pre_cyc + 1, ras_cyc - pre_cyc, 1);
    chk("R5 column strobe follows row", cas_cyc == ras_cyc + 1, cas_cyc - ras_cyc, 1);
    do_op(1'b0, 0, 1, 8'h00);

    // R7 idle refresh spacing and order
    wait_after_refresh();
    wait_after_refresh();
    spacing_chk = 1;
    repeat (3 * PER + 5) @(negedge clk);
    spacing_chk = 0;

    // R8 mixed traffic across refreshes, scoreboard compares reads
    for (int i = 0; i < 90; i++) begin
      int rr, cc;
      rr = int'($urandom_range(3, 0));
      cc = int'($urandom_range(3, 0));
      do_op(logic'($urandom_range(1, 0)), rr, cc, 8'($urandom_range(255, 0)));
    end
    // R6 full readback after refreshes
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        do_op(1'b0, r, c, 8'h00);
    repeat (4) @(negedge clk);
    chk("R3 all expected responses seen", exp_q.size() == 0, exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule